// File: doc/BRIEF.md
# CTU-Tiled Source Frame Packer

This block takes an 8-bit YUV 4:2:0 frame that arrives in raster order and turns it into a sequence of memory writes. The writes place the frame in coding-tree-unit tiles. The luma plane comes in on one valid/ready stream and the interleaved chroma plane on another. On each stream a beat is one 128-bit word. A luma word holds 16 horizontally adjacent samples. A chroma word holds 8 U,V pairs, with U of the first pair first. The block gives every tile of 64×64 luma samples its own 512-word slot. The slots are placed one after another in raster order of tiles, starting at a base word address.

A frame begins with a one-cycle start pulse. That pulse captures the width, height, base address and fill byte. The block then walks the whole padded frame one output word at a time, luma plane first and chroma plane second. Where the walk is inside the picture, it consumes an input word. Where the walk is past the right or bottom edge, it creates a fill word. Every output word leaves through a single registered valid/ready port that carries both address and data. A one-cycle done pulse marks the hand-off of the last word.

Top module: `ctu_tile_packer`

## Requirements
- R1: A luma word at padded row r and word column c (in units of 16 samples) goes to address base + T·512 + (r mod 64)·4 + (c mod 4). Its data is the input word unchanged, with the leftmost sample in bits 127:120.
- R2: A chroma word at chroma row r (0 to H/2−1 for real rows) and word column c (8 pairs per word) goes to base + T·512 + 256 + (r mod 32)·4 + (c mod 4). Its data is the input word unchanged.
- R3: The tile index T is (row div 64, or chroma row div 32)·ceil(W/64) + (c div 4). The address arithmetic wraps modulo 2^28.
- R4: A word column at or beyond ceil(W/16) produces a word with all 16 bytes equal to the fill byte.
- R5: When W mod 16 = 8, the last real word column of each real row keeps input bits 127:64 and replaces bits 63:0 with the fill byte.
- R6: Luma rows at or beyond H, and chroma rows at or beyond H/2, produce words of all fill bytes, up to the padded heights ceil(H/64)·64 and ceil(H/64)·32.
- R7: A frame emits exactly ceil(W/64)·ceil(H/64)·384 words. The order is all luma words in raster order of the padded grid, then all chroma words in the same order. No word follows the last one.
- R8: While out_valid is high and out_ready is low, out_valid, out_addr and out_data hold their values.
- R9: During reset, and after it, out_valid, busy, frame_done, lu_ready and ch_ready are low until a start is accepted.
- R10: A start is accepted only while busy is low; a start while busy changes nothing. frame_done pulses for one cycle on the cycle after the last word is accepted, and busy is low from then on.
- R11: lu_ready and ch_ready are never high together. Each is high only when the walk stands on a real position of its own plane and the output register can take a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse; ignored while busy |
| cfg_width | input | 11 | Frame width in luma samples, multiple of 8 |
| cfg_height | input | 11 | Frame height in luma rows, multiple of 8 |
| cfg_base | input | 28 | Word address of the first tile slot |
| cfg_fill | input | 8 | Byte used for padding |
| lu_valid | input | 1 | Luma word offered |
| lu_ready | output | 1 | Luma word taken this cycle |
| lu_data | input | 128 | 16 luma samples, leftmost in the MSB |
| ch_valid | input | 1 | Chroma word offered |
| ch_ready | output | 1 | Chroma word taken this cycle |
| ch_data | input | 128 | 8 U,V pairs, first U in the MSB |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the output word |
| out_addr | output | 28 | Word address of the output word |
| out_data | output | 128 | Output word |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse after the last word |

## Verification
The hardest case to reach is the partial right-edge word, which only appears when W mod 16 = 8. When it appears, it must coincide with the last real row of a tile that is partly filled at the bottom, and at the same time the sink has to stall the output. The stimulus table includes widths of 8, 136 and 200 and heights that are not multiples of 64. The sink's ready follows a pseudo-random sequence, and both sources insert bubbles. Together these place stalls on fill words, on partial words and on tile seams. One frame also receives a second start in the middle of the frame, and the bench confirms that the first frame's word stream goes on untouched.

// File: rtl/ctu_pack_pkg.sv
package ctu_pack_pkg;
  typedef enum logic {PLANE_Y = 1'b0, PLANE_C = 1'b1} plane_e;
  localparam int TILE_LOG   = 6;    // luma samples per tile side = 64
  localparam int SLOT_LOG   = 9;    // words per tile slot = 512
  localparam int CHROMA_OFS = 256;  // first chroma word inside a slot
endpackage

// File: rtl/ctu_scan_ctrl.sv
module ctu_scan_ctrl import ctu_pack_pkg::*; #(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic             advance,
  output logic             busy,
  output plane_e           plane,
  output logic [DIM_W:0]   row,
  output logic [DIM_W-4:0] col,
  output logic [DIM_W-6:0] ncx,
  output logic             pos_real,
  output logic             pos_part,
  output logic             pos_last
);
  localparam int ROW_W = DIM_W + 1;
  localparam int COL_W = DIM_W - 3;
  localparam int NC_W  = DIM_W - 5;

  logic [DIM_W:0]   w_ext, h_ext, lw_ext;
  logic [NC_W-1:0]  ncy_q;
  logic [COL_W-1:0] lw_q, last_col;
  logic [DIM_W-1:0] height_q;
  logic             half_q;
  logic [ROW_W-1:0] last_row, real_rows;

  assign w_ext  = {1'b0, cfg_width}  + ROW_W'(63);
  assign h_ext  = {1'b0, cfg_height} + ROW_W'(63);
  assign lw_ext = {1'b0, cfg_width}  + ROW_W'(15);

  always_comb begin
    last_col = {ncx, 2'b00} - COL_W'(1);
    if (plane == PLANE_C) begin
      last_row  = {1'b0, ncy_q, 5'b0} - ROW_W'(1);
      real_rows = {2'b00, height_q[DIM_W-1:1]};
    end else begin
      last_row  = {ncy_q, 6'b0} - ROW_W'(1);
      real_rows = {1'b0, height_q};
    end
    pos_real = (row < real_rows) && (col < lw_q);
    pos_part = pos_real && half_q && (col == lw_q - COL_W'(1));
    pos_last = (plane == PLANE_C) && (row == last_row) && (col == last_col);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      plane <= PLANE_Y;
      row   <= '0;
      col   <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      plane <= PLANE_Y;
      row   <= '0;
      col   <= '0;
    end else if (advance && busy) begin
      if (col != last_col) begin
        col <= col + COL_W'(1);
      end else begin
        col <= '0;
        if (row != last_row) begin
          row <= row + ROW_W'(1);
        end else begin
          row <= '0;
          if (plane == PLANE_Y) plane <= PLANE_C;
          else                  busy  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      ncx      <= w_ext[DIM_W:TILE_LOG];
      ncy_q    <= h_ext[DIM_W:TILE_LOG];
      lw_q     <= lw_ext[DIM_W:4];
      height_q <= cfg_height;
      half_q   <= cfg_width[3];
    end
  end

  // the walk never leaves the padded grid
  assert_col_in_grid_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (col <= last_col) && (row <= last_row));
endmodule

// File: rtl/ctu_word_addr.sv
module ctu_word_addr import ctu_pack_pkg::*; #(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 28
) (
  input  plane_e            plane,
  input  logic [DIM_W:0]    row,
  input  logic [DIM_W-4:0]  col,
  input  logic [DIM_W-6:0]  ncx,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam int ROW_W = DIM_W + 1;
  localparam int COL_W = DIM_W - 3;

  logic [ROW_W-6:0]    tile_y;
  logic [ADDR_W-1:0]   tile_idx;
  logic [SLOT_LOG-1:0] offset;

  always_comb begin
    if (plane == PLANE_C) begin
      tile_y = row[ROW_W-1:5];
      offset = SLOT_LOG'(CHROMA_OFS) + SLOT_LOG'({row[4:0], col[1:0]});
    end else begin
      tile_y = {1'b0, row[ROW_W-1:6]};
      offset = {1'b0, row[5:0], col[1:0]};
    end
    tile_idx = ADDR_W'(tile_y) * ADDR_W'(ncx) + ADDR_W'(col[COL_W-1:2]);
    addr     = base + (tile_idx << SLOT_LOG) + ADDR_W'(offset);
  end
endmodule

// File: rtl/ctu_word_fill.sv
module ctu_word_fill #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] din,
  input  logic [7:0]        fill,
  input  logic              is_real,
  input  logic              is_part,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;
  localparam int HALF   = DATA_W / 2;

  logic [DATA_W-1:0] fill_word;
  assign fill_word = {NBYTES{fill}};

  always_comb begin
    if (!is_real)     dout = fill_word;
    else if (is_part) dout = {din[DATA_W-1:HALF], fill_word[HALF-1:0]};
    else              dout = din;
  end
endmodule

// File: rtl/ctu_tile_packer.sv
module ctu_tile_packer import ctu_pack_pkg::*; #(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [7:0]        cfg_fill,
  input  logic              lu_valid,
  output logic              lu_ready,
  input  logic [DATA_W-1:0] lu_data,
  input  logic              ch_valid,
  output logic              ch_ready,
  input  logic [DATA_W-1:0] ch_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              busy,
  output logic              frame_done
);
  logic              scan_busy, pos_real, pos_part, pos_last;
  plane_e            plane;
  logic [DIM_W:0]    row;
  logic [DIM_W-4:0]  col;
  logic [DIM_W-6:0]  ncx;
  logic [ADDR_W-1:0] base_q, word_addr, out_off;
  logic [7:0]        fill_q;
  logic [DATA_W-1:0] in_word, word_data;
  logic              launch, slot_free, in_ok, advance, out_last, out_chroma;

  assign busy      = scan_busy || out_valid;
  assign launch    = start && !busy;
  assign slot_free = !out_valid || out_ready;
  assign in_ok     = (plane == PLANE_C) ? ch_valid : lu_valid;
  assign in_word   = (plane == PLANE_C) ? ch_data  : lu_data;
  assign advance   = scan_busy && slot_free && (!pos_real || in_ok);
  assign lu_ready  = scan_busy && slot_free && pos_real && (plane == PLANE_Y);
  assign ch_ready  = scan_busy && slot_free && pos_real && (plane == PLANE_C);

  ctu_scan_ctrl #(.DIM_W(DIM_W)) u_scan (
    .clk(clk), .rst(rst), .launch(launch),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .advance(advance),
    .busy(scan_busy), .plane(plane), .row(row), .col(col), .ncx(ncx),
    .pos_real(pos_real), .pos_part(pos_part), .pos_last(pos_last)
  );

  ctu_word_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr (
    .plane(plane), .row(row), .col(col), .ncx(ncx), .base(base_q),
    .addr(word_addr)
  );

  ctu_word_fill #(.DATA_W(DATA_W)) u_fill (
    .din(in_word), .fill(fill_q), .is_real(pos_real), .is_part(pos_part),
    .dout(word_data)
  );

  always_ff @(posedge clk) begin
    if (launch) begin
      base_q <= cfg_base;
      fill_q <= cfg_fill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_chroma <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= out_valid && out_ready && out_last;
      if (advance) begin
        out_valid  <= 1'b1;
        out_last   <= pos_last;
        out_chroma <= (plane == PLANE_C);
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      out_addr <= word_addr;
      out_data <= word_data;
    end
  end

  assign out_off = out_addr - base_q;

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));
  assert_one_ready_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lu_ready, ch_ready}));
  assert_luma_half_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_chroma |-> !out_off[SLOT_LOG-1]);
  assert_chroma_quarter_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_chroma |-> out_off[SLOT_LOG-1:SLOT_LOG-2] == 2'b10);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(base_q) && $stable(fill_q));
endmodule

// File: tb/ctu_tile_packer_tb.sv
module ctu_tile_packer_tb;
  localparam int NVEC = 5;
  // {width[57:47], height[46:36], base[35:8], fill[7:0]}
  localparam logic [57:0] VEC [NVEC] = '{
    {11'd64,  11'd64,  28'h0000100, 8'h80},
    {11'd136, 11'd72,  28'h0123400, 8'h80},
    {11'd8,   11'd8,   28'h0000007, 8'h5A},
    {11'd200, 11'd136, 28'h0400000, 8'h10},
    {11'd128, 11'd56,  28'h0002000, 8'hC3}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [10:0] cfg_width = '0, cfg_height = '0;
  logic [27:0] cfg_base = '0;
  logic [7:0] cfg_fill = '0;
  logic lu_valid = 1'b0, ch_valid = 1'b0, out_ready = 1'b0;
  logic [127:0] lu_data = '0, ch_data = '0;
  logic lu_ready, ch_ready, out_valid, busy, frame_done;
  logic [27:0] out_addr;
  logic [127:0] out_data;
  int errors = 0, checks = 0, cyc = 0;
  int cw, chh, cf;
  logic [27:0] cb;
  logic [7:0] lf = 8'hA5;

  always #2.5 clk = ~clk;

  ctu_tile_packer u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_base(cfg_base), .cfg_fill(cfg_fill),
    .lu_valid(lu_valid), .lu_ready(lu_ready), .lu_data(lu_data),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .busy(busy), .frame_done(frame_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, cycle %0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mkword(int pl, int r, int c);
    logic [127:0] w;
    for (int k = 0; k < 16; k++)
      w[127-8*k -: 8] = 8'(r*3 + c*17 + k + (pl != 0 ? 64 : 0));
    return w;
  endfunction

  task automatic drive_plane(int pl, int w, int h);
    int rows = (pl != 0) ? h/2 : h;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < (w+15)/16; c++) begin
        if (((r + c) % 7) == 3) begin
          if (pl != 0) ch_valid = 1'b0; else lu_valid = 1'b0;
          @(posedge clk); #1;
        end
        if (pl != 0) begin ch_valid = 1'b1; ch_data = mkword(1, r, c); end
        else         begin lu_valid = 1'b1; lu_data = mkword(0, r, c); end
        do @(negedge clk); while (!((pl != 0) ? ch_ready : lu_ready));
        @(posedge clk); #1;
      end
    if (pl != 0) ch_valid = 1'b0; else lu_valid = 1'b0;
  endtask

  task automatic sink(int total);
    int pl = 0, r = 0, c = 0, got = 0;
    int ncx = (cw+63)/64, ncy = (chh+63)/64, lw = (cw+15)/16;
    bit hold = 0, is_real, is_part;
    logic [27:0] ha, ea;
    logic [127:0] hd, ed, fw;
    string tag;
    fw = {16{8'(cf)}};
    while (got < total) begin
      @(negedge clk);
      chk(!(lu_ready && ch_ready), "R11 readies", {lu_ready, ch_ready}, 0);
      if (hold) chk(out_valid && out_addr == ha && out_data == hd, "R8 hold", out_data, hd);
      hold = out_valid && !out_ready; ha = out_addr; hd = out_data;
      if (out_valid && out_ready) begin
        is_real = (r < ((pl != 0) ? chh/2 : chh)) && (c < lw);
        is_part = is_real && (cw % 16 == 8) && (c == lw-1);
        ea = 28'(cb + (((pl != 0) ? r/32 : r/64)*ncx + c/4)*512 + ((pl != 0) ? 256 : 0)
             + ((pl != 0) ? r%32 : r%64)*4 + c%4);
        ed = is_real ? mkword(pl, r, c) : fw;
        if (is_part) ed[63:0] = fw[63:0];
        if (is_part) tag = "R5 partial";
        else if (!is_real) tag = (c >= lw) ? "R4 right fill" : "R6 bottom fill";
        else tag = (pl != 0) ? "R2 chroma data" : "R1 luma data";
        chk(out_addr == ea, "R3 address", 128'(out_addr), 128'(ea));
        chk(out_data == ed, tag, out_data, ed);
        got++;
        c++;
        if (c == ncx*4) begin
          c = 0; r++;
          if (r == ncy*((pl != 0) ? 32 : 64)) begin r = 0; pl++; end
        end
      end
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[1];
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: state while reset is held
    chk(!out_valid && !busy && !frame_done, "R9 in reset", {out_valid, busy, frame_done}, 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !busy && !lu_ready && !ch_ready && !frame_done, "R9 after reset",
        {out_valid, busy, lu_ready, ch_ready, frame_done}, 0);
    @(posedge clk); #1;

    for (int v = 0; v < NVEC; v++) begin
      cw = int'(VEC[v][57:47]); chh = int'(VEC[v][46:36]);
      cb = VEC[v][35:8]; cf = int'(VEC[v][7:0]);
      cfg_width = 11'(cw); cfg_height = 11'(chh); cfg_base = cb; cfg_fill = 8'(cf);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      fork
        drive_plane(0, cw, chh);
        drive_plane(1, cw, chh);
        sink(((cw+63)/64) * ((chh+63)/64) * 384);
        if (v == 1) begin
          // R10: a second start mid-frame with other settings must be ignored
          repeat (40) @(posedge clk);
          #1;
          cfg_width = 11'd64; cfg_height = 11'd64; cfg_base = 28'h0; cfg_fill = 8'h00;
          start = 1'b1;
          @(posedge clk); #1;
          start = 1'b0;
        end
      join
      @(negedge clk);
      chk(frame_done && !busy && !out_valid, "R10 done pulse", {frame_done, busy, out_valid}, 3'b100);
      @(negedge clk);
      chk(!frame_done, "R10 single pulse", 128'(frame_done), 0);
      repeat (3) @(negedge clk);
      chk(!out_valid && !busy, "R7 no extra words", {out_valid, busy}, 0);
      @(posedge clk); #1;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule